// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries data words from one clock domain to another when the two clocks have no fixed relation. A producer pushes words on the write clock, and a consumer pulls them on the read clock. Each side sees only flags and counts that are registered in its own domain. The words sit in a register array. The two position counters cross between domains only as Gray codes, each through a synchronizer chain whose depth is a parameter.

Each domain reports an approximate fill level. The write side computes it from its own counter and the synchronized read position, and the read side does the reverse. The write side also raises an almost-full flag at or above a programmable threshold, and the read side raises an almost-empty flag at or below another threshold. A refused request changes nothing. The depth must be a power of two of at least four, and the thresholds must lie within the depth; elaboration stops otherwise. The integrator must synchronize the release of each reset to its own clock.

A read returns its word on `rd_data` from a register, so the word is valid in the read-clock cycle after the edge that accepted the read.

Top module: `xclk_fifo`

## Requirements
- R1: While either reset is low, and right after both are released, `rd_empty`=1, `rd_almost_empty`=1, `wr_full`=0, `wr_almost_full`=0, and both levels are 0.
- R2: Words leave in the order they were written, with no loss and no duplication. The word taken by a read accepted on a `rd_clk` rising edge is presented on `rd_data` from that edge on.
- R3: A write request while `wr_full`=1 is ignored: no word is stored, no stored word is overwritten, and `wr_level` does not change.
- R4: A read request while `rd_empty`=1 is ignored: `rd_data` holds its value, `rd_level` stays 0, and the next word written is still the next word read.
- R5: `wr_full` rises on the write edge that accepts the DEPTH-th unread word. It falls no later than SYNC_STAGES+3 write clocks after a read frees an entry.
- R6: `rd_empty` rises on the read edge that takes the last stored word. It falls no later than SYNC_STAGES+3 read clocks after a write.
- R7: Once both sides have been idle for SYNC_STAGES+3 cycles of each clock, `wr_level` and `rd_level` both equal the number of stored words, and neither ever exceeds DEPTH. `wr_full`=1 exactly when `wr_level`=DEPTH, and `rd_empty`=1 exactly when `rd_level`=0.
- R8: `wr_almost_full`=1 exactly when `wr_level` >= ALMOST_FULL_TH, and `rd_almost_empty`=1 exactly when `rd_level` <= ALMOST_EMPTY_TH. Both flags update on the same edge as their level.
- R9: With space available, the block accepts one write on every write clock. With data available, it accepts one read on every read clock. Each crossing pointer changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free entry |
| wr_almost_full | output | 1 | Write-side level at or above ALMOST_FULL_TH |
| wr_level | output | $clog2(DEPTH)+1 | Fill level seen by the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word taken by the last accepted read |
| rd_empty | output | 1 | No stored word |
| rd_almost_empty | output | 1 | Read-side level at or below ALMOST_EMPTY_TH |
| rd_level | output | $clog2(DEPTH)+1 | Fill level seen by the read side |

## Verification
Two things can land in the same cycle. An accepted write can coincide with a read that the write side has not yet seen, and a read of the last word can coincide with a write that the read side has not yet seen. In both cases the registered flag decides whether the request is taken, based on a stale but safe view of the other pointer. The bench provokes this by running producer and consumer together. In one phase the read clock is faster, so the FIFO hovers at empty. In the other the read clock is slower, so it hovers at full. Both phases use irregular gaps. A scoreboard queue checks every delivered word against the written order, which exposes any word lost, repeated or overwritten near a boundary.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/xclk_sync_chain.sv
module xclk_sync_chain #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] r_stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) r_stage[i] <= '0;
    end else begin
      r_stage[0] <= d;
      for (int i = 1; i < STAGES; i++) r_stage[i] <= r_stage[i-1];
    end
  end

  assign q = r_stage[STAGES-1];
endmodule

// File: rtl/xclk_wptr.sv
module xclk_wptr
  import xclk_fifo_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int AFULL_TH = 12,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_sync,
  output logic          winc,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          afull,
  output logic [PW-1:0] level
);
  localparam logic [PW-1:0] TOP2 = {2'b11, {(PW-2){1'b0}}};

  logic [PW-1:0] r_bin, r_gray, r_level;
  logic          r_full, r_afull;
  logic [PW-1:0] w_bin_nx, w_gray_nx, w_rbin, w_level_nx;
  logic          w_full_nx, w_afull_nx;

  always_comb begin
    winc       = wr_en & ~r_full;
    w_bin_nx   = r_bin + PW'(winc);
    w_gray_nx  = PW'(to_gray(32'(w_bin_nx)));
    w_rbin     = PW'(from_gray(32'(rgray_sync)));
    w_level_nx = w_bin_nx - w_rbin;
    w_full_nx  = (w_gray_nx == (rgray_sync ^ TOP2));
    w_afull_nx = (w_level_nx >= PW'(AFULL_TH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_bin  <= '0;
      r_gray <= '0;
    end else if (winc) begin
      r_bin  <= w_bin_nx;
      r_gray <= w_gray_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_full  <= 1'b0;
      r_afull <= 1'b0;
      r_level <= '0;
    end else begin
      r_full  <= w_full_nx;
      r_afull <= w_afull_nx;
      r_level <= w_level_nx;
    end
  end

  assign waddr = r_bin[AW-1:0];
  assign wgray = r_gray;
  assign full  = r_full;
  assign afull = r_afull;
  assign level = r_level;
endmodule

// File: rtl/xclk_rptr.sv
module xclk_rptr
  import xclk_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int AEMPTY_TH = 2,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_sync,
  output logic          rinc,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic          aempty,
  output logic [PW-1:0] level
);
  logic [PW-1:0] r_bin, r_gray, r_level;
  logic          r_empty, r_aempty;
  logic [PW-1:0] w_bin_nx, w_gray_nx, w_wbin, w_level_nx;
  logic          w_empty_nx, w_aempty_nx;

  always_comb begin
    rinc        = rd_en & ~r_empty;
    w_bin_nx    = r_bin + PW'(rinc);
    w_gray_nx   = PW'(to_gray(32'(w_bin_nx)));
    w_wbin      = PW'(from_gray(32'(wgray_sync)));
    w_level_nx  = w_wbin - w_bin_nx;
    w_empty_nx  = (w_gray_nx == wgray_sync);
    w_aempty_nx = (w_level_nx <= PW'(AEMPTY_TH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_bin  <= '0;
      r_gray <= '0;
    end else if (rinc) begin
      r_bin  <= w_bin_nx;
      r_gray <= w_gray_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_empty  <= 1'b1;
      r_aempty <= 1'b1;
      r_level  <= '0;
    end else begin
      r_empty  <= w_empty_nx;
      r_aempty <= w_aempty_nx;
      r_level  <= w_level_nx;
    end
  end

  assign raddr  = r_bin[AW-1:0];
  assign rgray  = r_gray;
  assign empty  = r_empty;
  assign aempty = r_aempty;
  assign level  = r_level;
endmodule

// File: rtl/xclk_store.sv
module xclk_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] r_mem [DEPTH];
  logic [DATA_W-1:0] r_rdata;

  always_ff @(posedge wclk) begin
    if (we) r_mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  r_rdata <= '0;
    else if (re)  r_rdata <= r_mem[raddr];
  end

  assign rdata = r_rdata;
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int AFULL_TH    = 12,
  parameter int AEMPTY_TH   = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int PW         = AW + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_almost_full,
  output logic [PW-1:0]     wr_level,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_almost_empty,
  output logic [PW-1:0]     rd_level
);
  generate
    if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("xclk_fifo: DEPTH must be a power of two and at least 4");
    end
    if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xclk_fifo: SYNC_STAGES must be at least 2");
    end
    if (AFULL_TH < 1 || AFULL_TH > DEPTH || AEMPTY_TH < 0 || AEMPTY_TH >= DEPTH) begin : g_bad_th
      $error("xclk_fifo: threshold out of range");
    end
  endgenerate

  logic          w_winc, w_rinc;
  logic [AW-1:0] w_waddr, w_raddr;
  logic [PW-1:0] w_wgray, w_rgray, w_wgray_sync, w_rgray_sync;

  xclk_wptr #(.DEPTH(DEPTH), .AFULL_TH(AFULL_TH)) u_wptr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rgray_sync(w_rgray_sync),
    .winc(w_winc), .waddr(w_waddr), .wgray(w_wgray),
    .full(wr_full), .afull(wr_almost_full), .level(wr_level)
  );

  xclk_rptr #(.DEPTH(DEPTH), .AEMPTY_TH(AEMPTY_TH)) u_rptr (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wgray_sync(w_wgray_sync),
    .rinc(w_rinc), .raddr(w_raddr), .rgray(w_rgray),
    .empty(rd_empty), .aempty(rd_almost_empty), .level(rd_level)
  );

  xclk_sync_chain #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(w_wgray), .q(w_wgray_sync)
  );

  xclk_sync_chain #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(w_rgray), .q(w_rgray_sync)
  );

  xclk_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .wclk(wr_clk), .we(w_winc), .waddr(w_waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rd_rst_n), .re(w_rinc), .raddr(w_raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int PW     = 5
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              wr_en,
  input logic              wr_full,
  input logic              wr_almost_full,
  input logic [PW-1:0]     wr_level,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_empty,
  input logic              rd_almost_empty,
  input logic [PW-1:0]     rd_level,
  input logic [PW-1:0]     wgray,
  input logic [PW-1:0]     rgray
);
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full) |=> $stable(wgray)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_empty) |=> $stable(rgray)); // R4
  AST_HOLD_DATA_ON_EMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_empty) |=> $stable(rd_data)); // R4
  AST_WGRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R9
  AST_RGRAY_ONE_BIT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R9
  AST_FULL_MATCHES_LEVEL: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full == (wr_level == PW'(DEPTH))); // R7
  AST_EMPTY_MATCHES_LEVEL: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty == (rd_level == '0)); // R7
  AST_WLEVEL_BOUND: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_level <= PW'(DEPTH)); // R7
  AST_RLEVEL_BOUND: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_level <= PW'(DEPTH)); // R7
  AST_FULL_IMPLIES_AFULL: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |-> wr_almost_full); // R8
  AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |-> rd_almost_empty); // R8
endmodule

bind xclk_fifo xclk_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_full(wr_full),
  .wr_almost_full(wr_almost_full), .wr_level(wr_level),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
  .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty), .rd_level(rd_level),
  .wgray(w_wgray), .rgray(w_rgray)
);

// File: tb/xclk_fifo_tb.sv
`timescale 1ns/1ps
module xclk_fifo_tb;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int SYNC   = 2;
  localparam int AF_TH  = 12;
  localparam int AE_TH  = 2;
  localparam int PW     = $clog2(DEPTH) + 1;
  localparam int SETTLE = SYNC + 4;

  logic              wr_clk = 0, rd_clk = 0;
  logic              wr_rst_n, rd_rst_n, wr_en, rd_en;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              wr_full, wr_almost_full, rd_empty, rd_almost_empty;
  logic [PW-1:0]     wr_level, rd_level;

  int rd_half = 5;
  int checks = 0, errors = 0;
  int seq = 0;
  bit done = 0;
  logic [DATA_W-1:0] exp_q [$];

  always #4 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  xclk_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC),
              .AFULL_TH(AF_TH), .AEMPTY_TH(AE_TH)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_almost_full(wr_almost_full), .wr_level(wr_level),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty), .rd_level(rd_level)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: pushes each accepted word into the scoreboard queue.
  task automatic write_n(input int n, input int maxgap, output int stalls);
    stalls = 0;
    for (int i = 0; i < n; i++) begin
      bit taken = 0;
      int g = (maxgap > 0) ? $urandom_range(maxgap, 0) : 0;
      repeat (g) begin @(negedge wr_clk); wr_en = 0; end
      while (!taken) begin
        @(negedge wr_clk);
        if (!wr_full) begin
          wr_en = 1;
          wr_data = DATA_W'(seq * 32'h0100_0193 + 32'h5A);
          exp_q.push_back(wr_data);
          seq++;
          taken = 1;
        end else begin
          wr_en = 0;
          stalls++;
        end
      end
    end
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  // Monitor: pops the expected word one read cycle after each accepted read.
  task automatic read_n(input int n, input int maxgap, output int stalls);
    bit pending = 0;
    int got = 0;
    int gap = 0;
    stalls = 0;
    while (got < n || pending) begin
      @(negedge rd_clk);
      if (pending) begin
        if (exp_q.size() == 0) chk("R2 underrun", 1, 0);
        else chk("R2 order", rd_data, exp_q.pop_front());
        pending = 0;
      end
      if (got < n && gap == 0 && !rd_empty) begin
        rd_en = 1;
        pending = 1;
        got++;
        gap = (maxgap > 0) ? $urandom_range(maxgap, 0) : 0;
      end else begin
        rd_en = 0;
        if (got < n && gap == 0) stalls++;
        if (gap > 0) gap--;
      end
    end
    rd_en = 0;
  endtask

  task automatic settle();
    fork
      repeat (SETTLE) @(negedge wr_clk);
      repeat (SETTLE) @(negedge rd_clk);
    join
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int st;
    logic [DATA_W-1:0] held;
    wr_rst_n = 0; rd_rst_n = 0; wr_en = 0; rd_en = 0; wr_data = '0;
    repeat (3) @(negedge wr_clk);
    chk("R1 empty in reset", rd_empty, 1);
    chk("R1 full in reset", wr_full, 0);
    @(negedge wr_clk); wr_rst_n = 1;
    @(negedge rd_clk); rd_rst_n = 1;
    settle();
    chk("R1 empty", rd_empty, 1);
    chk("R1 almost_empty", rd_almost_empty, 1);
    chk("R1 full", wr_full, 0);
    chk("R1 almost_full", wr_almost_full, 0);
    chk("R1 wr_level", wr_level, 0);
    chk("R1 rd_level", rd_level, 0);

    // Fill with no reads, back to back
    write_n(DEPTH, 0, st);
    chk("R9 write stalls", st, 0);
    chk("R5 full after DEPTH writes", wr_full, 1);
    chk("R7 wr_level at full", wr_level, DEPTH);
    chk("R8 almost_full at full", wr_almost_full, 1);

    // Writes while full are refused
    for (int i = 0; i < 4; i++) begin
      @(negedge wr_clk); wr_en = 1; wr_data = 32'hDEAD_0000 + i;
    end
    @(negedge wr_clk); wr_en = 0;
    chk("R3 wr_level unchanged", wr_level, DEPTH);
    chk("R3 still full", wr_full, 1);
    settle();
    chk("R7 rd_level after sync", rd_level, DEPTH);
    chk("R8 almost_empty clear", rd_almost_empty, 0);
    chk("R6 not empty", rd_empty, 0);

    // Drain back to back; refused writes must not appear
    read_n(DEPTH, 0, st);
    chk("R9 read stalls", st, 0);
    chk("R6 empty after last read", rd_empty, 1);
    chk("R7 rd_level drained", rd_level, 0);
    chk("R3 queue drained", exp_q.size(), 0);
    repeat (SYNC + 3) @(negedge wr_clk);
    chk("R5 full released", wr_full, 0);
    chk("R7 wr_level drained", wr_level, 0);

    // Reads while empty are refused
    held = rd_data;
    for (int i = 0; i < 3; i++) begin @(negedge rd_clk); rd_en = 1; end
    @(negedge rd_clk); rd_en = 0;
    chk("R4 rd_data held", rd_data, held);
    chk("R4 rd_level stays 0", rd_level, 0);
    write_n(1, 0, st);
    repeat (SYNC + 3) @(negedge rd_clk);
    chk("R6 empty released", rd_empty, 0);
    read_n(1, 0, st);
    chk("R4 next word correct", exp_q.size(), 0);

    // Almost-empty boundary
    write_n(AE_TH + 1, 0, st);
    settle();
    chk("R8 level above AE_TH", rd_almost_empty, 0);
    chk("R7 rd_level", rd_level, AE_TH + 1);
    read_n(1, 0, st);
    chk("R8 level at AE_TH", rd_almost_empty, 1);
    chk("R7 rd_level after read", rd_level, AE_TH);

    // Almost-full boundary
    settle();
    write_n(AF_TH - 1 - AE_TH, 0, st);
    chk("R7 wr_level below AF_TH", wr_level, AF_TH - 1);
    chk("R8 below AF_TH", wr_almost_full, 0);
    write_n(1, 0, st);
    chk("R8 at AF_TH", wr_almost_full, 1);
    read_n(AF_TH, 0, st);
    chk("R6 empty after drain", rd_empty, 1);

    // Concurrent traffic, read clock faster
    rd_half = 3;
    fork
      write_n(150, 2, st);
      begin int s2; read_n(150, 0, s2); end
    join
    chk("R2 fast-read stream drained", exp_q.size(), 0);

    // Concurrent traffic, read clock slower: repeatedly full
    rd_half = 9;
    fork
      write_n(150, 0, st);
      begin int s2; read_n(150, 1, s2); end
    join
    chk("R3 slow-read stream drained", exp_q.size(), 0);
    chk("R5 writer was held off by full", (st > 0) ? 1 : 0, 1);
    settle();
    chk("R6 final empty", rd_empty, 1);
    chk("R7 final wr_level", wr_level, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule